// File: doc/BRIEF.md
# Multi-Source Interrupt Controller

This block merges five local interrupt sources into one request toward a bus bridge. The sources are a software trigger, a periodic timer, a change-of-state detector on 32 digital input lines, and two external pins. Each source has its own enable bit. A request raised by an enabled source is held as pending. Exactly one pending source at a time is granted ownership of the outgoing request. The grant is announced by a one-cycle pulse. The other pending sources wait in a queue until the owner is released.

Software drives the block through a small register port. Registers are written on a clock edge when `reg_wr` is high and read back combinationally on `reg_rdata`. A source is released by writing 0 to its enable bit, which discards its pending request. Writing 1 to the same bit re-arms it. After a change-of-state event, two registers hold the full input image from the cycle before the event and from the cycle of the event. The service routine can use them to see which lines moved.

Top module: `irq_hub`

## Requirements
- R1: After reset, every register reads 0, `irq_pulse` is low, and no pulse is issued until a source is enabled. The register addresses are: 0 flags, 1 status, 2 timer period, 3 low-line mask, 4 high-line mask, 5 pre-event snapshot, 6 post-event snapshot.
- R2: The flags register holds bit 7 (master enable) and bits 4..0 (per-source enables: bit 4 software, bit 3 timer, bit 2 change-of-state, bit 1 external 1, bit 0 external 0), and reads them back. Bit 6 is ignored. Bit 5 is a write-only trigger and always reads 0.
- R3: Status bits 4..0 are one-hot or zero and name the current owner, using the same bit order as the enables.
- R4: Each time a new owner is granted, `irq_pulse` is high for exactly one cycle. No grant is made while the master enable is 0, although requests still become pending.
- R5: Writing 0 to a source's enable clears that source's pending request. If that source is the owner, ownership is released and the next pending source is granted, with a fresh pulse.
- R6: When several requests are pending, the one granted first is software, then timer, then change-of-state, then external 1, then external 0.
- R7: Status bits 9..5 flag sources that are pending but do not own the request (bit 9 software down to bit 5 external 0). Bit 11 is 1 while an owner exists. Bits 10 and 31..12 read 0.
- R8: With timer period P ≠ 0, writing the timer enable on clock edge E raises a timer request on edge E+P, and the timer repeats every P cycles while enabled. A period of 0 raises no request.
- R9: A change-of-state request is raised when any input line changes value between two consecutive clock edges, provided its mask bit is 1 and its `dir_out` bit is 0. Lines 15..0 use the low mask, and lines 31..16 use the high mask.
- R10: When a change-of-state request is raised, the pre-event snapshot receives the input image of the previous cycle and the post-event snapshot receives the image that caused it. Line i is stored at bit i.
- R11: A high level on an external pin lasting a single clock cycle raises a request. A pin held high raises only one request per rising edge.
- R12: Events from a source whose enable is 0 are dropped and are not remembered. Writing bit 5 without bit 4 raises no software request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| din | input | 32 | Digital input line image |
| dir_out | input | 32 | Line direction, 1 = output (excluded from detection) |
| ext_in | input | 2 | External interrupt pins, bit 0 = external 0 |
| irq_pulse | output | 1 | One-cycle request pulse per grant |

## Verification
The bench queues all five sources while the master enable is off. It then releases them one at a time and checks the owner, the queued bits and the pulse count at each step. A wrong priority order or a failure to re-grant after a release would show up as the wrong owner bit or a missing pulse. It measures the cycle in which the first timer request appears, to catch an off-by-one period, and drives single-cycle and held-high external pulses to catch a synchronizer that drops short pulses or fires on level. Randomized masks, directions and line changes check that output lines and unmasked lines never trigger change-of-state, and that the snapshots hold the exact images around the event.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int NSRC        = 5;
    localparam int SRC_EXT0    = 0;
    localparam int SRC_EXT1    = 1;
    localparam int SRC_COS     = 2;
    localparam int SRC_TMR     = 3;
    localparam int SRC_SW      = 4;
    localparam int FLAG_FIRE   = 5;
    localparam int FLAG_MASTER = 7;
    localparam int NEXT        = 2;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [2:0] {
        A_FLAGS     = 3'd0,
        A_STATUS    = 3'd1,
        A_PERIOD    = 3'd2,
        A_MASK_LO   = 3'd3,
        A_MASK_HI   = 3'd4,
        A_SNAP_PRE  = 3'd5,
        A_SNAP_POST = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic     master;
        src_vec_t en;
    } flags_t;

    // Highest set bit wins: software sits at the top index.
    function automatic src_vec_t pick_top(input src_vec_t v);
        src_vec_t r;
        r = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (v[i]) r = src_vec_t'(1) << i;
        end
        return r;
    endfunction

    function automatic logic [31:0] pack_status(input src_vec_t own, input src_vec_t queued);
        return {20'd0, |own, 1'b0, queued, own};
    endfunction

endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // STAGES synchronizer flops plus one history flop for edge detection.
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], async_in};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R11

endmodule

// File: rtl/irq_hub_timer.sv
module irq_hub_timer #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] period,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = run && !restart && (period != '0) && (cnt == period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) cnt <= '0;
        else if (tick)              cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        (tick && period > W'(1) && !restart) |=> !tick); // R8

endmodule

// File: rtl/irq_hub_cos.sv
module irq_hub_cos #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] din,
    input  logic [LINES-1:0] dir_out,
    input  logic [LINES-1:0] mask,
    input  logic             arm,
    output logic             hit,
    output logic [LINES-1:0] snap_pre,
    output logic [LINES-1:0] snap_post
);
    logic [LINES-1:0] prev;
    logic [LINES-1:0] watch;

    assign watch = mask & ~dir_out;
    assign hit   = arm && (((din ^ prev) & watch) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev      <= '0;
            snap_pre  <= '0;
            snap_post <= '0;
        end else begin
            prev <= din;
            if (hit) begin
                snap_pre  <= prev;
                snap_post <= din;
            end
        end
    end

    AST_SNAP_DIFFERS: assert property (@(posedge clk) disable iff (rst)
        hit |=> ((snap_pre ^ snap_post) & $past(watch)) != '0); // R10

endmodule

// File: rtl/irq_hub_arb.sv
module irq_hub_arb
    import irq_hub_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     master,
    input  src_vec_t pending,
    output src_vec_t owner,
    output logic     irq_pulse
);
    src_vec_t owner_nxt;
    logic     keep;

    assign keep = (owner & pending) != '0;

    always_comb begin
        if (keep)        owner_nxt = owner;
        else if (master) owner_nxt = pick_top(pending);
        else             owner_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner     <= '0;
            irq_pulse <= 1'b0;
        end else begin
            owner     <= owner_nxt;
            irq_pulse <= (owner_nxt != '0) && !keep;
        end
    end

    AST_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(owner)); // R3
    AST_PULSE_NEW_OWNER: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (owner != '0) && (owner != $past(owner))); // R4
    AST_MASTER_OFF: assert property (@(posedge clk) disable iff (rst)
        !master |=> !irq_pulse); // R4
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (owner != '0 && (owner & pending) == '0) |=> (owner & $past(owner)) == '0); // R5
    AST_SW_FIRST: assert property (@(posedge clk) disable iff (rst)
        (owner == '0 && master && pending[SRC_SW]) |=> owner[SRC_SW]); // R6

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int PERIOD_W    = 28,
    parameter int LINES       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [LINES-1:0] din,
    input  logic [LINES-1:0] dir_out,
    input  logic [NEXT-1:0]  ext_in,
    output logic             irq_pulse
);
    localparam int HALF = LINES / 2;

    flags_t            flags;
    logic [PERIOD_W-1:0] period;
    logic [HALF-1:0]   mask_lo;
    logic [HALF-1:0]   mask_hi;
    src_vec_t          pending;
    src_vec_t          owner;
    src_vec_t          ev;
    src_vec_t          en_nxt;
    logic [NEXT-1:0]   ext_rise;
    logic              tick;
    logic              cos_hit;
    logic [LINES-1:0]  snap_pre;
    logic [LINES-1:0]  snap_post;
    logic              wr_flags;
    logic              wr_period;
    wire               unused_wdata = ^reg_wdata[31:PERIOD_W];

    assign wr_flags  = reg_wr && (reg_addr == A_FLAGS);
    assign wr_period = reg_wr && (reg_addr == A_PERIOD);
    assign en_nxt    = wr_flags ? reg_wdata[NSRC-1:0] : flags.en;

    genvar gi;
    generate
        for (gi = 0; gi < NEXT; gi++) begin : g_ext
            irq_hub_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk(clk), .rst(rst), .async_in(ext_in[gi]), .rise(ext_rise[gi])
            );
        end
    endgenerate

    irq_hub_timer #(.W(PERIOD_W)) u_timer (
        .clk(clk), .rst(rst), .run(flags.en[SRC_TMR]), .restart(wr_period),
        .period(period), .tick(tick)
    );

    irq_hub_cos #(.LINES(LINES)) u_cos (
        .clk(clk), .rst(rst), .din(din), .dir_out(dir_out),
        .mask({mask_hi, mask_lo}),
        .arm(flags.en[SRC_COS] && !pending[SRC_COS]),
        .hit(cos_hit), .snap_pre(snap_pre), .snap_post(snap_post)
    );

    always_comb begin
        ev           = '0;
        ev[SRC_SW]   = wr_flags && reg_wdata[FLAG_FIRE];
        ev[SRC_TMR]  = tick;
        ev[SRC_COS]  = cos_hit;
        ev[SRC_EXT1] = ext_rise[1];
        ev[SRC_EXT0] = ext_rise[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            period  <= '0;
            mask_lo <= '0;
            mask_hi <= '0;
            pending <= '0;
        end else begin
            pending <= (pending | ev) & en_nxt;
            if (wr_flags) begin
                flags.master <= reg_wdata[FLAG_MASTER];
                flags.en     <= reg_wdata[NSRC-1:0];
            end
            if (wr_period)                         period  <= reg_wdata[PERIOD_W-1:0];
            if (reg_wr && reg_addr == A_MASK_LO)   mask_lo <= reg_wdata[HALF-1:0];
            if (reg_wr && reg_addr == A_MASK_HI)   mask_hi <= reg_wdata[HALF-1:0];
        end
    end

    irq_hub_arb u_arb (
        .clk(clk), .rst(rst), .master(flags.master), .pending(pending),
        .owner(owner), .irq_pulse(irq_pulse)
    );

    always_comb begin
        case (reg_addr)
            A_FLAGS:     reg_rdata = {24'd0, flags.master, 2'b00, flags.en};
            A_STATUS:    reg_rdata = pack_status(owner, pending & ~owner);
            A_PERIOD:    reg_rdata = 32'(period);
            A_MASK_LO:   reg_rdata = 32'(mask_lo);
            A_MASK_HI:   reg_rdata = 32'(mask_hi);
            A_SNAP_PRE:  reg_rdata = 32'(snap_pre);
            A_SNAP_POST: reg_rdata = 32'(snap_post);
            default:     reg_rdata = '0;
        endcase
    end

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_flags && !reg_wdata[SRC_COS]) |=> !pending[SRC_COS]); // R5
    AST_IGNORE_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!flags.en[SRC_EXT0] && !wr_flags) |=> !pending[SRC_EXT0]); // R12

endmodule

// File: tb/irq_hub_tb.sv
module irq_hub_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] din = '0;
    logic [31:0] dir_out = '0;
    logic [1:0]  ext_in = '0;
    logic        irq_pulse;

    int checks = 0;
    int fails  = 0;
    int npulse = 0;
    int unsigned seed = 32'd20240611;

    irq_hub u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .din(din),
        .dir_out(dir_out), .ext_in(ext_in), .irq_pulse(irq_pulse)
    );

    always #4 clk = ~clk;

    always @(negedge clk) if (!rst && irq_pulse) npulse++;

    localparam logic [2:0] FL = 3'd0, ST = 3'd1, PER = 3'd2, MLO = 3'd3,
                           MHI = 3'd4, PRE = 3'd5, POST = 3'd6;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_status(input int own, input logic [4:0] pend);
        logic [4:0] o;
        o = (own < 0) ? 5'd0 : (5'd1 << own);
        return {20'd0, (own >= 0), 1'b0, pend & ~o, o};
    endfunction

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int p0;
        logic [31:0] ml, mh, dr, base, x, watch;
        v = $urandom(seed);
        idle(3);
        rst = 1'b0;
        idle(2);

        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R1 reset register", v, 32'd0);
        end
        chk("R1 no pulse", 32'(npulse), 32'd0);

        // R2, R4: master off keeps request queued; bit 5 and 6 read 0
        wr(FL, 32'h7F);
        idle(3);
        rd(FL, v);  chk("R2 flags readback", v, 32'h1F);
        rd(ST, v);  chk("R4 queued while master off", v, exp_status(-1, 5'b10000));
        chk("R4 no pulse master off", 32'(npulse), 32'd0);
        wr(FL, 32'hDF);
        idle(3);
        rd(FL, v);  chk("R2 bit6 ignored", v, 32'h9F);
        rd(ST, v);  chk("R3 software owner", v, exp_status(4, 5'b10000));
        chk("R4 one pulse", 32'(npulse), 32'd1);
        wr(FL, 32'h80);
        idle(3);
        rd(ST, v);  chk("R5 release clears", v, 32'd0);

        // R6, R7, R5: all five queued, released in order
        wr(MLO, 32'h1); wr(MHI, 32'h0);
        wr(PER, 32'd3);
        wr(FL, 32'h3F);
        @(negedge clk) ext_in = 2'b11;
        @(negedge clk) ext_in = 2'b00;
        @(negedge clk) din[0] = 1'b1;
        idle(10);
        p0 = npulse;
        rd(ST, v);  chk("R7 all queued", v, exp_status(-1, 5'b11111));
        wr(FL, 32'h9F); idle(3);
        rd(ST, v);  chk("R6 software first", v, exp_status(4, 5'b11111));
        wr(FL, 32'h8F); idle(3);
        rd(ST, v);  chk("R6 timer second", v, exp_status(3, 5'b01111));
        wr(FL, 32'h87); idle(3);
        rd(ST, v);  chk("R6 cos third", v, exp_status(2, 5'b00111));
        wr(FL, 32'h83); idle(3);
        rd(ST, v);  chk("R6 ext1 fourth", v, exp_status(1, 5'b00011));
        wr(FL, 32'h81); idle(3);
        rd(ST, v);  chk("R6 ext0 last", v, exp_status(0, 5'b00001));
        wr(FL, 32'h80); idle(3);
        rd(ST, v);  chk("R5 all released", v, 32'd0);
        chk("R5 pulse per grant", 32'(npulse - p0), 32'd5);
        din = '0;

        // R8: timer period timing
        wr(PER, 32'd10);
        wr(FL, 32'h88);
        idle(9);
        rd(ST, v);  chk("R8 not before P", v, 32'd0);
        idle(1);
        rd(ST, v);  chk("R8 request at P", v, exp_status(-1, 5'b01000));
        idle(1);
        rd(ST, v);  chk("R8 granted", v, exp_status(3, 5'b01000));
        wr(FL, 32'h80);
        wr(PER, 32'd0);
        wr(FL, 32'h88);
        idle(40);
        rd(ST, v);  chk("R8 period zero idle", v, 32'd0);
        wr(FL, 32'h80);

        // R11: single-cycle pulse, held level
        wr(FL, 32'h81);
        @(negedge clk) ext_in[0] = 1'b1;
        @(negedge clk) ext_in[0] = 1'b0;
        idle(6);
        rd(ST, v);  chk("R11 short pulse captured", v, exp_status(0, 5'b00001));
        wr(FL, 32'h82);
        @(negedge clk) ext_in[1] = 1'b1;
        idle(6);
        rd(ST, v);  chk("R11 ext1 edge", v, exp_status(1, 5'b00010));
        wr(FL, 32'h80); wr(FL, 32'h82);
        idle(6);
        rd(ST, v);  chk("R11 held level no repeat", v, 32'd0);
        ext_in[1] = 1'b0;

        // R12: disabled events dropped
        wr(FL, 32'h80);
        @(negedge clk) ext_in[0] = 1'b1;
        @(negedge clk) ext_in[0] = 1'b0;
        idle(6);
        wr(FL, 32'h81);
        idle(4);
        rd(ST, v);  chk("R12 disabled ext dropped", v, 32'd0);
        wr(FL, 32'hA0);
        idle(3);
        rd(ST, v);  chk("R12 fire without enable", v, 32'd0);

        // R9, R10: directed change-of-state
        wr(FL, 32'h80);
        wr(MLO, 32'h0008); wr(MHI, 32'h0001);
        dir_out = 32'h0000_0008; din = '0;
        idle(2);
        wr(FL, 32'h84);
        @(negedge clk) din = 32'h0000_0008;
        idle(3);
        rd(ST, v);  chk("R9 output line excluded", v, 32'd0);
        @(negedge clk) din = 32'h0001_0008;
        idle(3);
        rd(ST, v);  chk("R9 high-half line", v, exp_status(2, 5'b00100));
        rd(PRE, v); chk("R10 pre snapshot", v, 32'h0000_0008);
        rd(POST, v); chk("R10 post snapshot", v, 32'h0001_0008);

        // R9, R10: random masks, directions and changes
        for (int it = 0; it < 24; it++) begin
            ml = $urandom; mh = $urandom; dr = $urandom;
            base = $urandom; x = $urandom & $urandom & $urandom;
            watch = {mh[15:0], ml[15:0]} & ~dr;
            wr(FL, 32'h80);
            wr(MLO, ml); wr(MHI, mh);
            @(negedge clk); dir_out = dr; din = base;
            idle(2);
            wr(FL, 32'h84);
            p0 = npulse;
            @(negedge clk) din = base ^ x;
            idle(3);
            rd(ST, v);
            if ((x & watch) != 0) begin
                chk("R9 random hit", v, exp_status(2, 5'b00100));
                rd(PRE, v);  chk("R10 random pre", v, base);
                rd(POST, v); chk("R10 random post", v, base ^ x);
                chk("R4 random pulse", 32'(npulse - p0), 32'd1);
            end else begin
                chk("R9 random no hit", v, 32'd0);
                chk("R4 random no pulse", 32'(npulse - p0), 32'd0);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule